// File: doc/BRIEF.md
# Horizontal Parallelism Batch Hazard Checker

This block decides whether two vector element operations may be issued as free of register and memory hazards. It uses a 7-bit parallelism hint supplied with the loop. Elements whose step index, divided by the hint and rounded down, gives the same quotient belong to one batch, and elements inside one batch are independent. Source and destination steps are judged the same way. The caller presents whichever pair it wants compared. The steps are the raw loop counters, taken before any remapping or predicate masking. The hint can be any value from 1 to 127, including values that are not a power of two.

Issue logic can declare a smaller group size of its own. In that case a pair is independent only when it shares a batch under the hint and also shares a group under the smaller size. Some memory operations must never be merged: atomic operations, cache-inhibited accesses, and reserve/conditional-store accesses. When any of these flags is raised, the block behaves exactly as if the hint were zero. A hint of zero means no pair is independent.

The division is a combinational restoring divider, replicated once for each quotient the block needs. The verdict and both batch numbers are registered, and they appear one cycle after a valid request together with a valid strobe.

Top module: `hb_batch_top`

## Requirements
- R1: `outValid` is high in the cycle after a cycle with `inValid` high, and low otherwise. While `inValid` is low, `sameBatch`, `batchA` and `batchB` keep their previous values.
- R2: With an effective hint h from 1 to 127, `batchA` = floor(`stepA`/h) and `batchB` = floor(`stepB`/h), for any h including non-powers of two.
- R3: With an effective hint h and no active group limit, `sameBatch` is 1 exactly when floor(`stepA`/h) equals floor(`stepB`/h).
- R4: With `hint` = 0, `sameBatch` is 0 for every pair, and `batchA`/`batchB` report the raw steps `stepA`/`stepB`.
- R5: When any of `memAtomic`, `memCacheInh` or `memResv` is 1, the hint is treated as 0 and the outputs follow R4 whatever the value of `hint`.
- R6: When `grpLimit` g is nonzero and smaller than the effective hint h, `sameBatch` is 1 only if floor(step/h) and floor(step/g) both match for the two steps. The batch outputs still use h. A `grpLimit` of 0, or one of at least h, has no effect.
- R7: Equal steps give `sameBatch` = 1 whenever the effective hint is nonzero.
- R8: When the hint exceeds both steps (for example, a hint larger than the vector length), both batch numbers are 0 and, with no active group limit, `sameBatch` is 1.
- R9: During and after reset, before any request, `outValid`, `sameBatch`, `batchA` and `batchB` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; the inputs below are sampled when high |
| hint | input | STEP_W | Parallelism hint; 0 means no hint |
| grpLimit | input | STEP_W | Hardware group size; 0 means use the hint alone |
| stepA | input | STEP_W | Step index of the first element, before remapping |
| stepB | input | STEP_W | Step index of the second element, before remapping |
| memAtomic | input | 1 | Atomic memory operation |
| memCacheInh | input | 1 | Cache-inhibited memory operation |
| memResv | input | 1 | Reserve or conditional-store memory operation |
| outValid | output | 1 | Result strobe, one cycle after the request |
| sameBatch | output | 1 | Pair may be treated as hazard-free |
| batchA | output | STEP_W | Batch number of the first element |
| batchB | output | STEP_W | Batch number of the second element |

## Verification
The memory-class override and the group-limit clamp can both act on the same request, and both choose the divisor in the same cycle. The bench provokes this in two ways. It drives directed vectors with equal steps, a nonzero hint and an active group limit while one memory flag is raised. It also mixes random flags with random group limits. Each result is judged against a bench model: the override must win, which means `sameBatch` is low and the batch outputs equal the raw steps. The clamp must apply only when no flag is raised.

// File: rtl/hb_batch_pkg.sv
package hb_batch_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic hintOff;   // effective hint is zero
    logic useLimit;  // group limit is tighter than the hint
  } hbCtl_t;
endpackage

// File: rtl/hb_divider.sv
// Unrolled restoring divider; divisor must be nonzero.
module hb_divider #(
  parameter int W = 7
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient
);
  logic [W-1:0] remS  [0:W-1];
  logic [W:0]   partS [0:W-1];
  logic [W-1:0] geS;

  assign remS[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_stage
    assign partS[k] = {remS[k], dividend[W-1-k]};
    assign geS[k]   = partS[k] >= {1'b0, divisor};
    assign quotient[W-1-k] = geS[k];
    if (k < W - 1) begin : g_rem
      assign remS[k+1] = geS[k] ? (partS[k][W-1:0] - divisor) : partS[k][W-1:0];
    end
  end
endmodule

// File: rtl/hb_batch_ctrl.sv
module hb_batch_ctrl
  import hb_batch_pkg::*;
#(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [STEP_W-1:0] hint,
  input  logic [STEP_W-1:0] grpLimit,
  input  logic              memAtomic,
  input  logic              memCacheInh,
  input  logic              memResv,
  output hbCtl_t            ctl,
  output logic              outValid
);
  logic memBlock;

  assign memBlock = memAtomic | memCacheInh | memResv;

  always_comb begin
    ctl.load     = inValid;
    ctl.hintOff  = memBlock || (hint == '0);
    ctl.useLimit = (grpLimit != '0) && (grpLimit < hint);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/hb_batch_dp.sv
module hb_batch_dp
  import hb_batch_pkg::*;
#(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbCtl_t            ctl,
  input  logic [STEP_W-1:0] hint,
  input  logic [STEP_W-1:0] grpLimit,
  input  logic [STEP_W-1:0] stepA,
  input  logic [STEP_W-1:0] stepB,
  output logic              sameBatch,
  output logic [STEP_W-1:0] batchA,
  output logic [STEP_W-1:0] batchB
);
  localparam int N_DIV = 4;  // A/hint, B/hint, A/group, B/group
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  logic [STEP_W-1:0] hintDiv, grpDiv;
  logic [STEP_W-1:0] dvdArr [0:N_DIV-1];
  logic [STEP_W-1:0] dvsArr [0:N_DIV-1];
  logic [STEP_W-1:0] quoArr [0:N_DIV-1];
  logic              nextSame;
  logic [STEP_W-1:0] nextA, nextB;

  assign hintDiv = ctl.hintOff  ? ONE      : hint;
  assign grpDiv  = ctl.useLimit ? grpLimit : hintDiv;

  assign dvdArr[0] = stepA;  assign dvsArr[0] = hintDiv;
  assign dvdArr[1] = stepB;  assign dvsArr[1] = hintDiv;
  assign dvdArr[2] = stepA;  assign dvsArr[2] = grpDiv;
  assign dvdArr[3] = stepB;  assign dvsArr[3] = grpDiv;

  for (genvar d = 0; d < N_DIV; d++) begin : g_div
    hb_divider #(.W(STEP_W)) div_i (
      .dividend(dvdArr[d]),
      .divisor (dvsArr[d]),
      .quotient(quoArr[d])
    );
  end

  always_comb begin
    nextSame = !ctl.hintOff && (quoArr[0] == quoArr[1]) && (quoArr[2] == quoArr[3]);
    nextA    = ctl.hintOff ? stepA : quoArr[0];
    nextB    = ctl.hintOff ? stepB : quoArr[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sameBatch <= 1'b0;
      batchA    <= '0;
      batchB    <= '0;
    end else if (ctl.load) begin
      sameBatch <= nextSame;
      batchA    <= nextA;
      batchB    <= nextB;
    end
  end
endmodule

// File: rtl/hb_batch_top.sv
module hb_batch_top
  import hb_batch_pkg::*;
#(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [STEP_W-1:0] hint,
  input  logic [STEP_W-1:0] grpLimit,
  input  logic [STEP_W-1:0] stepA,
  input  logic [STEP_W-1:0] stepB,
  input  logic              memAtomic,
  input  logic              memCacheInh,
  input  logic              memResv,
  output logic              outValid,
  output logic              sameBatch,
  output logic [STEP_W-1:0] batchA,
  output logic [STEP_W-1:0] batchB
);
  hbCtl_t ctl;

  hb_batch_ctrl #(.STEP_W(STEP_W)) ctrl_i (
    .clk, .rstN, .inValid, .hint, .grpLimit,
    .memAtomic, .memCacheInh, .memResv,
    .ctl, .outValid
  );

  hb_batch_dp #(.STEP_W(STEP_W)) dp_i (
    .clk, .rstN, .ctl, .hint, .grpLimit, .stepA, .stepB,
    .sameBatch, .batchA, .batchB
  );
endmodule

// File: rtl/hb_batch_check.sv
module hb_batch_check #(
  parameter int STEP_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [STEP_W-1:0] hint,
  input logic [STEP_W-1:0] grpLimit,
  input logic [STEP_W-1:0] stepA,
  input logic [STEP_W-1:0] stepB,
  input logic              memAtomic,
  input logic              memCacheInh,
  input logic              memResv,
  input logic              outValid,
  input logic              sameBatch,
  input logic [STEP_W-1:0] batchA,
  input logic [STEP_W-1:0] batchB
);
  logic memAny;
  assign memAny = memAtomic | memCacheInh | memResv;

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(sameBatch) && $stable(batchA) && $stable(batchB)));
  // R4
  zero_hint_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && hint == '0) |=> (!sameBatch && batchA == $past(stepA) && batchB == $past(stepB)));
  // R5
  mem_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && memAny) |=> (!sameBatch && batchA == $past(stepA)));
  // R7
  self_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !memAny && hint != '0 && stepA == stepB) |=> sameBatch);
  // R8
  wide_hint_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !memAny && stepA < hint && stepB < hint) |=> (batchA == '0 && batchB == '0));
  // R3
  same_implies_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && sameBatch) |-> (batchA == batchB));
endmodule

bind hb_batch_top hb_batch_check #(.STEP_W(STEP_W)) chk_i (.*);

// File: tb/hb_batch_top_tb_top.sv
`timescale 1ns/1ps
module hb_batch_top_tb_top;
  localparam int W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] hint = '0, grpLimit = '0, stepA = '0, stepB = '0;
  logic memAtomic = 1'b0, memCacheInh = 1'b0, memResv = 1'b0;
  logic outValid, sameBatch;
  logic [W-1:0] batchA, batchB;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_batch_top #(.STEP_W(W)) dut_i (
    .clk, .rstN, .inValid, .hint, .grpLimit, .stepA, .stepB,
    .memAtomic, .memCacheInh, .memResv,
    .outValid, .sameBatch, .batchA, .batchB
  );

  function automatic int expEff(int h, bit at, bit ci, bit rs);
    return (at || ci || rs) ? 0 : h;
  endfunction

  function automatic bit expSame(int h, int lim, int a, int b);
    int g;
    if (h == 0) return 1'b0;
    g = (lim == 0 || lim > h) ? h : lim;
    return (a / h == b / h) && (a / g == b / g);
  endfunction

  function automatic int expBatch(int h, int s);
    return (h == 0) ? s : s / h;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive at a negedge, check at the next negedge (one register stage).
  task automatic runVec(string tag, int h, int lim, int a, int b, bit at, bit ci, bit rs);
    int e;
    hint = W'(h); grpLimit = W'(lim); stepA = W'(a); stepB = W'(b);
    memAtomic = at; memCacheInh = ci; memResv = rs; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    e = expEff(h, at, ci, rs);
    chk(tag, "outValid", int'(outValid), 1);
    chk(tag, "sameBatch", int'(sameBatch), int'(expSame(e, lim, a, b)));
    chk(tag, "batchA", int'(batchA), expBatch(e, a));
    chk(tag, "batchB", int'(batchB), expBatch(e, b));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int pa, pb, ps;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "outValid", int'(outValid), 0);
    chk("R9", "sameBatch", int'(sameBatch), 0);
    chk("R9", "batchA", int'(batchA), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", "batchB after reset", int'(batchB), 0);

    runVec("R2", 5, 0, 14, 12, 0, 0, 0);
    runVec("R2", 5, 0, 15, 14, 0, 0, 0);
    runVec("R3", 7, 0, 13, 7, 0, 0, 0);
    runVec("R3", 1, 0, 3, 4, 0, 0, 0);
    runVec("R4", 0, 0, 9, 9, 0, 0, 0);
    runVec("R5", 10, 0, 3, 3, 1, 0, 0);
    runVec("R5", 10, 0, 3, 3, 0, 1, 0);
    runVec("R5", 10, 4, 3, 3, 0, 0, 1);
    runVec("R6", 12, 4, 5, 9, 0, 0, 0);
    runVec("R6", 12, 4, 5, 6, 0, 0, 0);
    runVec("R6", 12, 20, 5, 9, 0, 0, 0);
    runVec("R7", 127, 0, 127, 127, 0, 0, 0);
    runVec("R8", 127, 0, 0, 126, 0, 0, 0);
    runVec("R8", 100, 0, 99, 0, 0, 0, 0);

    // R1: idle cycle with new inputs must not disturb the held result
    pa = int'(batchA); pb = int'(batchB); ps = int'(sameBatch);
    hint = 7'd3; stepA = 7'd0; stepB = 7'd90; inValid = 1'b0;
    @(negedge clk);
    chk("R1", "outValid idle", int'(outValid), 0);
    chk("R1", "batchA held", int'(batchA), pa);
    chk("R1", "batchB held", int'(batchB), pb);
    chk("R1", "sameBatch held", int'(sameBatch), ps);

    for (int i = 0; i < 400; i++) begin
      int h, lim, a, b, sel;
      h   = int'($urandom_range(0, 127));
      lim = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 127)) : 0;
      a   = int'($urandom_range(0, 127));
      b   = ($urandom_range(0, 3) == 0) ? a + int'($urandom_range(0, 4)) : int'($urandom_range(0, 127));
      if (b > 127) b = 127;
      sel = int'($urandom_range(0, 11));
      runVec("R2", h, lim, a, b, sel == 0, sel == 1, sel == 2);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule